// File: doc/BRIEF.md
# Speculative Short-Sense Read Controller with Retry

This block sits on the controller side of a resistive memory array and sequences one line read at a time. Every accepted read is first launched with a shortened sense window. The captured line is then shown to an external check that catches bits which lost their value in one direction only. When the check is clean, the line is returned at once. When the check flags an error, the same address is launched again with the full sense window. The array contents are unharmed by a short sense, so the second capture is returned as it is, marked as a slow read. The result is a latency with two values. The fast value is the common case and the slow value is rare.

The short and full sense lengths come in as cycle counts on two ports, so they can be tuned without touching the design. Two saturating counters record how many reads were accepted and how many of them needed the second, full-length launch. Their ratio gives the retry rate, from which the average latency follows. The analog sensing, the cell array and the error check itself are outside the block.

Top module: `early_sense_rd_ctrl`

## Requirements
- R1: While rst_ni is low, req_ready_o is 1, rsp_valid_o is 0, arr_launch_o is 0, and both statistics outputs are 0.
- R2: A request is taken only when req_valid_i and req_ready_o are both high. req_ready_o is 0 from the cycle after acceptance until the cycle after the response handshake. A request held on req_valid_i while busy causes no launch and is not counted.
- R3: The cycle after acceptance, arr_launch_o is 1 for exactly one cycle, with arr_full_o = 0 (short sense) and arr_addr_o equal to the accepted address.
- R4: A launch opens a sense window of T cycles, where T is early_cycles_i for a short launch and full_cycles_i for a full launch. arr_data_i is captured at the clock edge that closes the window. For a read with no error, rsp_valid_o rises E+1 clock edges after the accepting edge, where E is the short length, and rsp_slow_o = 0.
- R5: If det_err_i is high in the cycle after a short-sense capture, the controller relaunches the same address with arr_full_o = 1. rsp_valid_o then rises E+1+F edges after acceptance, where F is the full length. The response carries the full-sense data with rsp_slow_o = 1.
- R6: The data from a full-sense launch is returned without consulting det_err_i. A read is launched at most twice.
- R7: While rsp_valid_o is 1 and rsp_ready_i is 0, rsp_valid_o, rsp_data_o and rsp_slow_o hold their values.
- R8: stat_reads_o increments once per accepted request and stat_retries_o once per full-sense relaunch. Both stop at 2^STAT_W-1. stat_retries_o never exceeds stat_reads_o.
- R9: A sense length of 0 on either length input acts as a length of 1.
- R10: arr_launch_o is never high on two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| early_cycles_i | input | CNT_W | Short sense length in cycles |
| full_cycles_i | input | CNT_W | Full sense length in cycles |
| req_valid_i | input | 1 | Read request valid |
| req_ready_o | output | 1 | Controller idle, request may be taken |
| req_addr_i | input | ADDR_W | Line address of the request |
| rsp_valid_o | output | 1 | Response line valid |
| rsp_ready_i | input | 1 | Requester takes the response |
| rsp_data_o | output | DATA_W | Captured line; also feeds the external error check |
| rsp_slow_o | output | 1 | Response came from a full-sense relaunch |
| arr_launch_o | output | 1 | One-cycle strobe that starts a sense |
| arr_full_o | output | 1 | Sense length select: 0 short, 1 full |
| arr_addr_o | output | ADDR_W | Address presented to the array |
| arr_data_i | input | DATA_W | Sensed line from the array |
| det_err_i | input | 1 | Unidirectional error flag for rsp_data_o |
| stat_reads_o | output | STAT_W | Accepted read count, saturating |
| stat_retries_o | output | STAT_W | Full-sense relaunch count, saturating |

## Verification
The assertions assume that det_err_i is a settled, glitch-free level in every cycle. They also assume that the array holds arr_data_i steady for the address and length select it is given, so that a capture reflects the launched mode. The bench meets both conditions with a combinational array model and a combinational ones-count check. The model clears only set bits, and only on short launches of reads chosen for fault injection. The bench sets the length inputs only while the controller is idle. This keeps a sense window fixed once it has started. Request and response handshakes are driven on the falling edge, with random response stalls.

// File: rtl/esr_pkg.sv
package esr_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SENSE = 2'd1,
    ST_CHECK = 2'd2,
    ST_RESP  = 2'd3
  } esr_state_e;
endpackage

// File: rtl/esr_sense_timer.sv
module esr_sense_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] len_i,
  output logic             done_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             run_q;

  assign done_o = run_q && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (load_i) begin
      // zero length behaves as one cycle
      cnt_q <= (len_i == '0) ? '0 : len_i - CNT_W'(1);
      run_q <= 1'b1;
    end else if (run_q) begin
      if (cnt_q == '0) run_q <= 1'b0;
      else             cnt_q <= cnt_q - CNT_W'(1);
    end
  end
endmodule

// File: rtl/esr_sat_counter.sv
module esr_sat_counter #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         inc_i,
  output logic [W-1:0] value_o
);
  localparam logic [W-1:0] MaxVal = '1;
  logic [W-1:0] val_q;

  assign value_o = val_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      val_q <= '0;
    else if (inc_i && val_q != MaxVal) val_q <= val_q + W'(1);
  end
endmodule

// File: rtl/early_sense_rd_ctrl.sv
module early_sense_rd_ctrl
  import esr_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 64,
  parameter int CNT_W  = 8,
  parameter int STAT_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CNT_W-1:0]  early_cycles_i,
  input  logic [CNT_W-1:0]  full_cycles_i,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [ADDR_W-1:0] req_addr_i,
  output logic              rsp_valid_o,
  input  logic              rsp_ready_i,
  output logic [DATA_W-1:0] rsp_data_o,
  output logic              rsp_slow_o,
  output logic              arr_launch_o,
  output logic              arr_full_o,
  output logic [ADDR_W-1:0] arr_addr_o,
  input  logic [DATA_W-1:0] arr_data_i,
  input  logic              det_err_i,
  output logic [STAT_W-1:0] stat_reads_o,
  output logic [STAT_W-1:0] stat_retries_o
);
  localparam int NumStat = 2;

  esr_state_e        state_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] line_q;
  logic              full_q;
  logic              launch_q;
  logic              accept, retry, sense_done;
  logic [CNT_W-1:0]  sense_len;

  assign accept    = req_valid_i && (state_q == ST_IDLE);
  assign retry     = (state_q == ST_CHECK) && det_err_i;
  assign sense_len = accept ? early_cycles_i : full_cycles_i;

  esr_sense_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (accept || retry),
    .len_i  (sense_len),
    .done_o (sense_done)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      addr_q   <= '0;
      line_q   <= '0;
      full_q   <= 1'b0;
      launch_q <= 1'b0;
    end else begin
      launch_q <= accept || retry;
      unique case (state_q)
        ST_IDLE: if (accept) begin
          addr_q  <= req_addr_i;
          full_q  <= 1'b0;
          state_q <= ST_SENSE;
        end
        ST_SENSE: if (sense_done) begin
          line_q  <= arr_data_i;
          // a full-length capture skips the check
          state_q <= full_q ? ST_RESP : ST_CHECK;
        end
        ST_CHECK: if (det_err_i) begin
          full_q  <= 1'b1;
          state_q <= ST_SENSE;
        end else begin
          state_q <= ST_RESP;
        end
        ST_RESP: if (rsp_ready_i) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready_o  = (state_q == ST_IDLE);
  assign rsp_valid_o  = (state_q == ST_RESP);
  assign rsp_data_o   = line_q;
  assign rsp_slow_o   = full_q;
  assign arr_launch_o = launch_q;
  assign arr_full_o   = full_q;
  assign arr_addr_o   = addr_q;

  logic [NumStat-1:0] stat_inc;
  logic [STAT_W-1:0]  stat_val [NumStat];
  assign stat_inc = {retry, accept};

  for (genvar g = 0; g < NumStat; g++) begin : g_stat
    esr_sat_counter #(.W(STAT_W)) u_cnt (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .inc_i   (stat_inc[g]),
      .value_o (stat_val[g])
    );
  end

  assign stat_reads_o   = stat_val[0];
  assign stat_retries_o = stat_val[1];
endmodule

// File: rtl/esr_chk.sv
module esr_chk #(
  parameter int DATA_W = 64,
  parameter int STAT_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic              req_ready_o,
  input logic              rsp_valid_o,
  input logic              rsp_ready_i,
  input logic [DATA_W-1:0] rsp_data_o,
  input logic              rsp_slow_o,
  input logic              arr_launch_o,
  input logic              arr_full_o,
  input logic              det_err_i,
  input logic [STAT_W-1:0] stat_reads_o,
  input logic [STAT_W-1:0] stat_retries_o
);
  // R2
  rsp_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> !req_ready_o);
  // R3
  early_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> (arr_launch_o && !arr_full_o));
  // R5
  retry_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (arr_launch_o && arr_full_o) |-> $past(det_err_i));
  // R7
  rsp_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && !rsp_ready_i) |=>
      (rsp_valid_o && $stable(rsp_data_o) && $stable(rsp_slow_o)));
  // R10
  launch_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arr_launch_o |=> !arr_launch_o);
  // R8
  reads_mono_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (stat_reads_o >= $past(stat_reads_o)));
  // R8
  retry_le_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_retries_o <= stat_reads_o);
endmodule

bind early_sense_rd_ctrl esr_chk #(.DATA_W(DATA_W), .STAT_W(STAT_W)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .req_valid_i    (req_valid_i),
  .req_ready_o    (req_ready_o),
  .rsp_valid_o    (rsp_valid_o),
  .rsp_ready_i    (rsp_ready_i),
  .rsp_data_o     (rsp_data_o),
  .rsp_slow_o     (rsp_slow_o),
  .arr_launch_o   (arr_launch_o),
  .arr_full_o     (arr_full_o),
  .det_err_i      (det_err_i),
  .stat_reads_o   (stat_reads_o),
  .stat_retries_o (stat_retries_o)
);

// File: tb/early_sense_rd_ctrl_test.sv
`timescale 1ns/1ps
module early_sense_rd_ctrl_test;
  localparam int AW = 16, DW = 64, CW = 8, SW = 4;
  localparam int SMAX = (1 << SW) - 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [CW-1:0] early_len = 8'd48, full_len = 8'd69;
  logic req_valid = 1'b0, rsp_ready = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic req_ready, rsp_valid, rsp_slow, arr_launch, arr_full, det_err;
  logic [DW-1:0] rsp_data, arr_data;
  logic [AW-1:0] arr_addr;
  logic [SW-1:0] st_reads, st_retries;

  logic [AW-1:0] cur_addr = '0;
  bit inject = 1'b0, force_det = 1'b0;
  int n_launch = 0, n_full = 0;
  logic [AW-1:0] last_launch_addr = '0;
  int checks = 0, fails = 0;
  int exp_reads = 0, exp_retries = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  early_sense_rd_ctrl #(.ADDR_W(AW), .DATA_W(DW), .CNT_W(CW), .STAT_W(SW)) uut (
    .clk_i(clk), .rst_ni(rst_n), .early_cycles_i(early_len), .full_cycles_i(full_len),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_addr_i(req_addr),
    .rsp_valid_o(rsp_valid), .rsp_ready_i(rsp_ready), .rsp_data_o(rsp_data),
    .rsp_slow_o(rsp_slow), .arr_launch_o(arr_launch), .arr_full_o(arr_full),
    .arr_addr_o(arr_addr), .arr_data_i(arr_data), .det_err_i(det_err),
    .stat_reads_o(st_reads), .stat_retries_o(st_retries));

  function automatic logic [DW-1:0] mem_word(input logic [AW-1:0] a);
    logic [31:0] x;
    x = {16'h0, a};
    return {x * 32'h9E3779B1, (x ^ 32'h5A5A) * 32'h85EBCA6B} | 64'h1;
  endfunction

  // array: short launch of an injected read drops the lowest set bit (1 -> 0 only)
  logic [DW-1:0] stored;
  assign stored   = mem_word(arr_addr);
  assign arr_data = (inject && !arr_full) ? (stored & (stored - 64'h1)) : stored;
  // ones-count check against the stored line
  assign det_err  = force_det || ($countones(rsp_data) != $countones(mem_word(cur_addr)));

  always @(posedge clk) if (rst_n && arr_launch) begin
    n_launch <= n_launch + 1;
    if (arr_full) n_full <= n_full + 1;
    last_launch_addr <= arr_addr;
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic int eff(input int v);
    return (v == 0) ? 1 : v;
  endfunction

  task automatic do_read(input logic [AW-1:0] a, input bit inj, input bit frc, input int stall);
    int lat, l0, f0, te, tf, exp_lat;
    bit slow;
    logic [DW-1:0] held;
    te = eff(int'(early_len)); tf = eff(int'(full_len));
    slow = inj | frc;
    exp_lat = slow ? te + 1 + tf : te + 1;
    l0 = n_launch; f0 = n_full;
    @(negedge clk);
    cur_addr = a; inject = inj; force_det = frc;
    req_addr = a; req_valid = 1'b1;
    chk(req_ready == 1'b1, "R2 idle ready", req_ready, 1);
    @(posedge clk);
    @(negedge clk);
    req_addr = a ^ 16'h00FF;  // keep a request pending while busy
    lat = 0;
    while (!rsp_valid && lat < 2000) begin
      chk(req_ready == 1'b0, "R2 busy not ready", req_ready, 0);
      @(negedge clk); lat++;
    end
    exp_reads   = (exp_reads < SMAX) ? exp_reads + 1 : SMAX;
    if (slow) exp_retries = (exp_retries < SMAX) ? exp_retries + 1 : SMAX;
    chk(lat == exp_lat, slow ? "R5 retry latency" : "R4 early latency", lat, exp_lat);
    chk(rsp_data == mem_word(a), slow ? "R6 full data" : "R4 early data", rsp_data, mem_word(a));
    chk(rsp_slow == slow, slow ? "R5 slow flag" : "R4 fast flag", rsp_slow, slow);
    chk(n_launch - l0 == (slow ? 2 : 1), "R6 launch count", n_launch - l0, slow ? 2 : 1);
    chk(n_full - f0 == (slow ? 1 : 0), "R3 full launch count", n_full - f0, slow ? 1 : 0);
    chk(last_launch_addr == a, "R3 launch addr", last_launch_addr, a);
    held = rsp_data;
    for (int i = 0; i < stall; i++) begin
      @(negedge clk);
      chk(rsp_valid && rsp_data == held && rsp_slow == slow, "R7 hold", rsp_data, held);
    end
    req_valid = 1'b0;
    rsp_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rsp_ready = 1'b0;
    inject = 1'b0; force_det = 1'b0;
    chk(!rsp_valid && req_ready, "R2 back to idle", {rsp_valid, req_ready}, 1);
    chk(st_reads == SW'(exp_reads), "R8 reads count", st_reads, exp_reads);
    chk(st_retries == SW'(exp_retries), "R8 retry count", st_retries, exp_retries);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20150209));
    repeat (3) @(negedge clk);
    // R1
    chk(req_ready && !rsp_valid && !arr_launch, "R1 reset outputs",
        {req_ready, rsp_valid, arr_launch}, 3'b100);
    chk(st_reads == '0 && st_retries == '0, "R1 reset counters", {st_reads, st_retries}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    // directed: default lengths
    do_read(16'h0012, 1'b0, 1'b0, 2);   // R4
    do_read(16'h0345, 1'b1, 1'b0, 1);   // R5
    do_read(16'h0678, 1'b0, 1'b1, 0);   // R6 false flag, full capture returned
    // R9 zero lengths
    early_len = 8'd0; full_len = 8'd0;
    do_read(16'h0ABC, 1'b0, 1'b0, 0);
    do_read(16'h0DEF, 1'b1, 1'b0, 0);
    early_len = 8'd1; full_len = 8'd2;
    do_read(16'hFFFF, 1'b1, 1'b0, 3);
    // random mix, drives both counters into saturation (R8)
    for (int k = 0; k < 40; k++) begin
      int e;
      e = 1 + int'($urandom_range(19));
      early_len = CW'(e);
      full_len  = CW'(e + int'($urandom_range(20)));
      do_read(AW'($urandom), ($urandom_range(1) == 1), ($urandom_range(7) == 0),
              int'($urandom_range(3)));
    end
    chk(st_reads == SW'(SMAX), "R8 reads saturated", st_reads, SMAX);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule